// File: doc/BRIEF.md
# MSI Doorbell Interrupt Frame

This block is a 4 KB register frame on a simple register bus that converts message-signalled interrupt writes into interrupt pulses. A device or bridge writes an absolute interrupt number into the doorbell register. The frame subtracts its first mapped interrupt number, which is the base parameter plus 32. If the result falls inside the configured window, the frame raises a one-cycle pulse on the matching output line. The output lines feed a downstream interrupt controller that treats them as edge-triggered shared peripheral inputs.

Software finds the mapped window through a read-only type register. A fixed identification register and a block of zero-reading identification slots complete the frame. Out-of-window interrupt numbers, writes of the wrong access size, accesses to unmapped offsets and narrow reads change nothing and never raise an error. A parameter set that allows more than 128 lines, or that pushes the window past interrupt number 1020, stops elaboration.

Top module: `msi_irq_frame`

## Requirements
- R1: A 4-byte read of offset 0x008 returns (BASE_INT+32) in bits [25:16] and NUM_LINES in bits [10:0]. All other bits are zero.
- R2: A doorbell write (offset 0x040) whose ID is at least BASE_INT+32 and below BASE_INT+32+NUM_LINES drives output line (ID − BASE_INT − 32) high. The line is high for exactly the one cycle after the write cycle, and every other line stays low.
- R3: Only bits [9:0] of the doorbell write data form the ID. Set bits at position 10 and above do not change which line pulses.
- R4: A doorbell ID below BASE_INT+32, or at or above BASE_INT+32+NUM_LINES, pulses no line.
- R5: Writes with bus_size 2 or 4 (the size is a byte count) are accepted. Writes of any other size pulse no line.
- R6: A 4-byte read of offset 0xFCC returns 0x05100000. This is the code 0x51 at bit 20, with zero implementer and revision fields.
- R7: A 4-byte read of any offset from 0xFD0 to 0xFFC returns zero.
- R8: Reads of unmapped offsets, and of the write-only doorbell, return zero. Writes to any offset other than 0x040 pulse no line.
- R9: A read whose bus_size is not 4 returns zero.
- R10: During and right after reset, every output line is low and bus_rdata is zero.
- R11: Doorbell writes in two consecutive cycles to two different valid IDs produce two one-cycle pulses, on their two lines, in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_size | input | 4 | Access size in bytes |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd, zero otherwise |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses, one bit per line |

## Verification
The hardest cases to reach are the two edges of the window and back-to-back doorbells. An off-by-one in the rebase shows up only at the first ID, the last ID, and the IDs just outside them. Two accepted writes in adjacent cycles are the only way to prove that each pulse is cleared and replaced, not held or merged. The bench uses a non-zero base so that the rebase is not an identity. Its vector table hits IDs first−1, first, last and last+1, plus an ID with junk above bit 9. A directed sequence then issues two doorbells on consecutive clock cycles and checks each cycle of the output bank.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam int FRAME_AW   = 12;
    localparam int BUS_DW     = 32;
    localparam int SIZE_W     = 4;
    localparam int ID_W       = 10;
    localparam int SPI_FIRST  = 32;
    localparam int MAX_LINES  = 128;
    localparam int MAX_ID     = 1020;
    localparam int CNT_W      = 11;
    localparam int FIRST_LSB  = 16;
    localparam int PROD_LSB   = 20;

    localparam logic [7:0] PROD_CODE = 8'h51;

    localparam logic [FRAME_AW-1:0] OFS_TYPE    = 12'h008;
    localparam logic [FRAME_AW-1:0] OFS_DOOR    = 12'h040;
    localparam logic [FRAME_AW-1:0] OFS_IDENT   = 12'hFCC;
    localparam logic [FRAME_AW-1:0] OFS_IDBLK_L = 12'hFD0;
    localparam logic [FRAME_AW-1:0] OFS_IDBLK_H = 12'hFFC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TYPE,
        SEL_DOOR,
        SEL_IDENT,
        SEL_IDBLK
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr_ok;
        logic     rd_ok;
    } access_s;

    typedef struct packed {
        logic          hit;
        logic [ID_W-1:0] offs;
    } rebase_s;

    function automatic reg_sel_e map_offset(input logic [FRAME_AW-1:0] a);
        if (a == OFS_TYPE)                            return SEL_TYPE;
        if (a == OFS_DOOR)                            return SEL_DOOR;
        if (a == OFS_IDENT)                           return SEL_IDENT;
        if (a >= OFS_IDBLK_L && a <= OFS_IDBLK_H)     return SEL_IDBLK;
        return SEL_NONE;
    endfunction

    function automatic logic write_size_ok(input logic [SIZE_W-1:0] s);
        return (s == SIZE_W'(2)) || (s == SIZE_W'(4));
    endfunction

    function automatic logic read_size_ok(input logic [SIZE_W-1:0] s);
        return s == SIZE_W'(4);
    endfunction

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
    import msi_frame_pkg::*;
(
    input  logic [FRAME_AW-1:0] addr,
    input  logic [SIZE_W-1:0]   size,
    input  logic                wr,
    input  logic                rd,
    output access_s             acc
);
    always_comb begin
        acc.sel   = map_offset(addr);
        acc.wr_ok = wr && write_size_ok(size);
        acc.rd_ok = rd && read_size_ok(size);
    end
endmodule

// File: rtl/msi_frame_rdmux.sv
module msi_frame_rdmux
    import msi_frame_pkg::*;
#(
    parameter int BASE_INT  = 0,
    parameter int NUM_LINES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  access_s           acc,
    output logic [BUS_DW-1:0] rdata
);
    localparam int FIRST_ID = BASE_INT + SPI_FIRST;

    localparam logic [BUS_DW-1:0] TYPE_VAL =
        (BUS_DW'(FIRST_ID) << FIRST_LSB) | BUS_DW'(NUM_LINES);
    localparam logic [BUS_DW-1:0] IDENT_VAL =
        BUS_DW'(PROD_CODE) << PROD_LSB;

    logic [BUS_DW-1:0] rd_value;

    always_comb begin
        unique case (acc.sel)
            SEL_TYPE:  rd_value = TYPE_VAL;
            SEL_IDENT: rd_value = IDENT_VAL;
            default:   rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)             rdata <= '0;
        else if (acc.rd_ok)  rdata <= rd_value;
        else                 rdata <= '0;
    end
endmodule

// File: rtl/msi_id_rebase.sv
module msi_id_rebase
    import msi_frame_pkg::*;
#(
    parameter int BASE_INT  = 0,
    parameter int NUM_LINES = 64
) (
    input  logic            en,
    input  logic [ID_W-1:0] id,
    output rebase_s         res
);
    localparam int FIRST_ID = BASE_INT + SPI_FIRST;
    localparam int LIMIT_ID = FIRST_ID + NUM_LINES;

    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(FIRST_ID);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT_ID);

    logic [CNT_W-1:0] id_ext;
    logic [CNT_W-1:0] diff;
    logic             at_or_above;
    logic             below_limit;

    always_comb begin
        id_ext      = {1'b0, id};
        diff        = id_ext - FIRST_C;
        at_or_above = id_ext >= FIRST_C;
        below_limit = id_ext <  LIMIT_C;
        res.hit     = en && at_or_above && below_limit;
        res.offs    = diff[ID_W-1:0];
    end
endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank
    import msi_frame_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rebase_s              req,
    output logic [NUM_LINES-1:0] pulse
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic sel_i;
        assign sel_i = req.hit && (req.offs == ID_W'(i));

        always_ff @(posedge clk) begin
            if (rst) pulse[i] <= 1'b0;
            else     pulse[i] <= sel_i;
        end
    end
endmodule

// File: rtl/msi_irq_frame.sv
module msi_irq_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE_INT  = 0,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [3:0]           bus_size,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_pulse
);
    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_count
        $error("msi_irq_frame: NUM_LINES out of range 1..128");
    end
    if (BASE_INT < 0 || BASE_INT + SPI_FIRST + NUM_LINES > MAX_ID) begin : g_bad_base
        $error("msi_irq_frame: window passes interrupt number 1020");
    end

    access_s acc;
    rebase_s rb;
    logic    door_wr;
    logic    unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_DW-1:ID_W];

    msi_frame_decode u_decode (
        .addr (bus_addr),
        .size (bus_size),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .acc  (acc)
    );

    assign door_wr = acc.wr_ok && (acc.sel == SEL_DOOR);

    msi_id_rebase #(
        .BASE_INT  (BASE_INT),
        .NUM_LINES (NUM_LINES)
    ) u_rebase (
        .en  (door_wr),
        .id  (bus_wdata[ID_W-1:0]),
        .res (rb)
    );

    msi_pulse_bank #(
        .NUM_LINES (NUM_LINES)
    ) u_pulses (
        .clk   (clk),
        .rst   (rst),
        .req   (rb),
        .pulse (irq_pulse)
    );

    msi_frame_rdmux #(
        .BASE_INT  (BASE_INT),
        .NUM_LINES (NUM_LINES)
    ) u_rdmux (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/msi_irq_frame_chk.sv
module msi_irq_frame_chk #(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic [11:0]          bus_addr,
    input logic [3:0]           bus_size,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] irq_pulse
);
    // R2: at most one line pulses in a cycle
    p_one_line_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse));

    // R2: no pulse appears without a write in the previous cycle
    p_no_wr_no_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> (irq_pulse == '0));

    // R5: a wrongly sized write pulses nothing
    p_bad_size_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_size != 4'd2 && bus_size != 4'd4) |=> (irq_pulse == '0));

    // R8: a write away from the doorbell pulses nothing
    p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != 12'h040) |=> (irq_pulse == '0));

    // R8: read data is zero when no read was issued
    p_idle_rdata_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

    // R9: a narrow read returns zero
    p_narrow_rd_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size != 4'd4) |=> (bus_rdata == '0));

    // R10: reset clears outputs
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (irq_pulse == '0 && bus_rdata == '0));
endmodule

bind msi_irq_frame msi_irq_frame_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse)
);

// File: tb/msi_irq_frame_tb.sv
module msi_irq_frame_tb;
    localparam int BASE  = 16;
    localparam int NUM   = 64;
    localparam int FIRST = BASE + 32;
    localparam int NVEC  = 17;
    localparam logic [7:0] NONE = 8'hFF;

    typedef struct packed {
        logic        is_wr;
        logic [11:0] addr;
        logic [3:0]  size;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [7:0]  exp_line;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 12'h008, 4'd4, 32'h0, 32'h0030_0040, NONE, 8'd1},  // R1
        '{1'b0, 12'hFCC, 4'd4, 32'h0, 32'h0510_0000, NONE, 8'd6},  // R6
        '{1'b0, 12'hFD0, 4'd4, 32'h0, 32'h0, NONE, 8'd7},          // R7
        '{1'b0, 12'hFE8, 4'd4, 32'h0, 32'h0, NONE, 8'd7},          // R7
        '{1'b0, 12'hFFC, 4'd4, 32'h0, 32'h0, NONE, 8'd7},          // R7
        '{1'b0, 12'h100, 4'd4, 32'h0, 32'h0, NONE, 8'd8},          // R8
        '{1'b0, 12'h008, 4'd2, 32'h0, 32'h0, NONE, 8'd9},          // R9
        '{1'b1, 12'h040, 4'd4, 32'd48, 32'h0, 8'd0, 8'd2},         // R2 first ID
        '{1'b1, 12'h040, 4'd4, 32'd111, 32'h0, 8'd63, 8'd2},       // R2 last ID
        '{1'b1, 12'h040, 4'd4, 32'd47, 32'h0, NONE, 8'd4},         // R4 below
        '{1'b1, 12'h040, 4'd4, 32'd112, 32'h0, NONE, 8'd4},        // R4 above
        '{1'b1, 12'h040, 4'd4, 32'hFFFF_FC3C, 32'h0, 8'd12, 8'd3}, // R3 high junk
        '{1'b1, 12'h040, 4'd2, 32'd70, 32'h0, 8'd22, 8'd5},        // R5 size 2
        '{1'b1, 12'h040, 4'd1, 32'd70, 32'h0, NONE, 8'd5},         // R5 size 1
        '{1'b1, 12'h040, 4'd8, 32'd70, 32'h0, NONE, 8'd5},         // R5 size 8
        '{1'b1, 12'h044, 4'd4, 32'd70, 32'h0, NONE, 8'd8},         // R8 wrong offset
        '{1'b0, 12'h040, 4'd4, 32'h0, 32'h0, NONE, 8'd8}           // R8 doorbell read
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [11:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [3:0]       bus_size = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [31:0]      bus_rdata;
    logic [NUM-1:0]   irq_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    msi_irq_frame #(.BASE_INT(BASE), .NUM_LINES(NUM)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_size  (bus_size),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    function automatic logic [NUM-1:0] line_vec(input logic [7:0] ln);
        return (ln == NONE) ? '0 : (NUM'(1) << ln);
    endfunction

    task automatic check(input bit ok, input int req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [3:0] s,
                          input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d;
        bus_wr = w; bus_rd = !w;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs low while in reset
        check(irq_pulse == '0 && bus_rdata == '0, 10, {irq_pulse, bus_rdata}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(irq_pulse == '0 && bus_rdata == '0, 10, {irq_pulse, bus_rdata}, '0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i].is_wr, VEC[i].addr, VEC[i].size, VEC[i].data);
            if (VEC[i].is_wr) begin
                check(irq_pulse == line_vec(VEC[i].exp_line), int'(VEC[i].req),
                      128'(irq_pulse), 128'(line_vec(VEC[i].exp_line)));
                @(negedge clk);
                // R2: pulse lasts one cycle only
                check(irq_pulse == '0, 2, 128'(irq_pulse), '0);
            end else begin
                check(bus_rdata == VEC[i].exp_rd, int'(VEC[i].req),
                      128'(bus_rdata), 128'(VEC[i].exp_rd));
                check(irq_pulse == '0, int'(VEC[i].req), 128'(irq_pulse), '0);
            end
        end

        // R11: two doorbells on consecutive cycles
        @(negedge clk);
        bus_addr = 12'h040; bus_size = 4'd4; bus_wdata = 32'(FIRST + 2); bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 32'(FIRST + 12);
        check(irq_pulse == line_vec(8'd2), 11, 128'(irq_pulse), 128'(line_vec(8'd2)));
        @(negedge clk);
        bus_wr = 1'b0;
        check(irq_pulse == line_vec(8'd12), 11, 128'(irq_pulse), 128'(line_vec(8'd12)));
        @(negedge clk);
        check(irq_pulse == '0, 11, 128'(irq_pulse), '0);

        // R10: reset right after a doorbell write suppresses the pulse
        bus_wdata = 32'(FIRST + 5); bus_wr = 1'b1; rst = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(irq_pulse == '0 && bus_rdata == '0, 10, {irq_pulse, bus_rdata}, '0);
        rst = 1'b0;
        @(negedge clk);

        // R1: type register still correct after reset
        access(1'b0, 12'h008, 4'd4, 32'h0);
        check(bus_rdata == 32'h0030_0040, 1, 128'(bus_rdata), 128'(32'h0030_0040));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule